// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Peripheral Slave

This block sits on the peripheral side of a processor bus whose low address byte and data byte share one set of eight lines. A latch strobe marks the first bus state of every machine cycle; while it is high the block captures the shared byte as the low address, the separate upper address byte, and three status lines that tell memory space from I/O space and the kind of transfer. The captured cycle information is held until the next strobe and is reported to local logic as a cycle kind, a space flag, a 16-bit address and a window-hit flag.

The block owns a small byte register file that is split into a memory bank and an I/O bank. The memory bank answers a parameterised memory address window. The I/O bank answers a parameterised port window that is decoded from the latched low byte alone. Instruction fetches and data reads are served from the same memory bank but are reported as different cycle kinds. A read cycle makes the block drive the addressed byte onto the shared lines only while the read strobe is low. A write cycle stores the last byte seen on the shared lines while the write strobe was low, at the strobe's rising edge. All bus inputs are sampled on the block clock.

Top module: `mxbus_slave`

## Requirements
- R1: After synchronous reset `cyc_kind` is 0, `cyc_addr` is 0, `cyc_io` and `cyc_hit` are 0, `bus_oe` is 0, `bus_out` is 0, and every register file byte reads back as 0.
- R2: On each clock edge with `addr_latch` high, `cyc_addr[7:0]` takes `bus_in`. While `addr_latch` is low, `cyc_addr`, `cyc_kind` and `cyc_io` hold their values, whatever `bus_in` carries.
- R3: `cyc_addr[15:8]` takes `addr_upper` on the same edges as R2, so for memory cycles `cyc_addr` is the full 16-bit address.
- R4: `cyc_kind` is decoded from {`io_space`, `cyc_status[1]`, `cyc_status[0]`} latched with the address. 011 gives 1 (instruction fetch), 010 gives 2 (memory read), 001 gives 3 (memory write), 110 gives 4 (I/O read), and 101 gives 5 (I/O write). Every other combination gives 0 (no transfer). `cyc_io` equals the latched `io_space`.
- R5: In I/O cycles only `cyc_addr[7:0]` selects the port. The upper byte has no effect on the hit flag or on the byte served.
- R6: `bus_oe` is 1 exactly when `rd_strobe_n` is low, `cyc_hit` is 1, and `cyc_kind` is 1, 2 or 4. It never rises during the latch state or during write cycles.
- R7: While `bus_oe` is 1, `bus_out` carries the register file byte at the addressed entry. While `bus_oe` is 0, `bus_out` is 0.
- R8: In a write cycle (kind 3 or 5) with `cyc_hit` 1, the byte last present on `bus_in` while `wr_strobe_n` was low is stored on the clock edge that sees `wr_strobe_n` high after low. A read of the same entry then returns it.
- R9: Cycles outside the window of their space neither drive the bus nor change any stored byte.
- R10: An instruction fetch (kind 1) and a memory read (kind 2) of the same address return the same memory bank byte.
- R11: `cyc_hit` is 1 when the latched kind is not 0 and the latched address falls in the memory window (memory space) or in the port window (I/O space). The memory and I/O banks are separate storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Shared address/data lines as seen by the slave |
| bus_out | output | 8 | Byte driven onto the shared lines during a served read |
| bus_oe | output | 1 | Output enable for `bus_out` onto the shared lines |
| addr_upper | input | 8 | Upper address byte |
| addr_latch | input | 1 | Address latch strobe, high in the first state of a cycle |
| io_space | input | 1 | 1 selects I/O space, 0 selects memory space |
| cyc_status | input | 2 | Cycle status pair, bit 1 and bit 0 as used in R4 |
| rd_strobe_n | input | 1 | Active-low read strobe |
| wr_strobe_n | input | 1 | Active-low write strobe |
| cyc_kind | output | 3 | Decoded cycle kind (R4 encoding) |
| cyc_addr | output | 16 | Latched cycle address |
| cyc_io | output | 1 | Latched space flag |
| cyc_hit | output | 1 | Latched address is inside the window of its space |

## Verification
The bench places the memory window at 0x40F8 with 16 bytes. This window crosses an upper-byte boundary, so both the carry in the 16-bit compare and the offset arithmetic are exercised. Addresses such as 0x41F8 would alias if only the low byte were decoded. The port window is set at 0xFC with 4 bytes, at the very top of the 8-bit port range, which probes the end compare without wrap. With these values the first and last entries of both banks, the neighbours just outside each window, and a port access with a foreign upper byte can all be reached.

// File: rtl/mxbus_pkg.sv
`timescale 1ns/1ps
package mxbus_pkg;

    typedef enum logic [2:0] {
        KIND_NONE    = 3'd0,
        KIND_FETCH   = 3'd1,
        KIND_MREAD   = 3'd2,
        KIND_MWRITE  = 3'd3,
        KIND_IOREAD  = 3'd4,
        KIND_IOWRITE = 3'd5
    } kind_e;

    typedef struct packed {
        logic        io;
        kind_e       kind;
        logic [15:0] addr;
    } cyc_t;

    function automatic kind_e classify(input logic io, input logic [1:0] st);
        kind_e k;
        case ({io, st})
            3'b011:  k = KIND_FETCH;
            3'b010:  k = KIND_MREAD;
            3'b001:  k = KIND_MWRITE;
            3'b110:  k = KIND_IOREAD;
            3'b101:  k = KIND_IOWRITE;
            default: k = KIND_NONE;
        endcase
        return k;
    endfunction

    function automatic logic is_read(input kind_e k);
        return (k == KIND_FETCH) || (k == KIND_MREAD) || (k == KIND_IOREAD);
    endfunction

    function automatic logic is_write(input kind_e k);
        return (k == KIND_MWRITE) || (k == KIND_IOWRITE);
    endfunction

endpackage

// File: rtl/mxbus_latch.sv
`timescale 1ns/1ps
module mxbus_latch
    import mxbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_latch,
    input  logic [7:0] bus_in,
    input  logic [7:0] addr_upper,
    input  logic       io_space,
    input  logic [1:0] cyc_status,
    output cyc_t       cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{io: 1'b0, kind: KIND_NONE, addr: 16'h0000};
        end else if (addr_latch) begin
            cur <= '{io: io_space,
                     kind: classify(io_space, cyc_status),
                     addr: {addr_upper, bus_in}};
        end
    end

    // R2: the low byte comes from the shared lines during the strobe
    assert_low_capture_R2: assert property (@(posedge clk) disable iff (rst)
        addr_latch |=> (cur.addr[7:0] == $past(bus_in)));

    // R2: nothing moves while the strobe is low
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !addr_latch |=> $stable(cur));

    // R3: the upper byte is taken with the low byte
    assert_upper_capture_R3: assert property (@(posedge clk) disable iff (rst)
        addr_latch |=> (cur.addr[15:8] == $past(addr_upper)));

    // R4: a space flag of 1 never yields a memory kind
    assert_space_kind_R4: assert property (@(posedge clk) disable iff (rst)
        cur.io |-> (cur.kind == KIND_NONE || cur.kind == KIND_IOREAD ||
                    cur.kind == KIND_IOWRITE));

endmodule

// File: rtl/mxbus_decode.sv
`timescale 1ns/1ps
module mxbus_decode
    import mxbus_pkg::*;
#(
    parameter logic [15:0] MEM_BASE  = 16'h4000,
    parameter int unsigned MEM_WORDS = 16,
    parameter logic [7:0]  IO_BASE   = 8'h80,
    parameter int unsigned IO_WORDS  = 8,
    localparam int unsigned DEPTH    = MEM_WORDS + IO_WORDS,
    localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  cyc_t             cur,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    localparam logic [16:0] MEM_LO = {1'b0, MEM_BASE};
    localparam logic [16:0] MEM_HI = {1'b0, MEM_BASE} + 17'(MEM_WORDS);
    localparam logic [8:0]  IO_LO  = {1'b0, IO_BASE};
    localparam logic [8:0]  IO_HI  = {1'b0, IO_BASE} + 9'(IO_WORDS);

    logic        mem_in, io_in;
    logic [15:0] mem_off;
    logic [7:0]  io_off;

    always_comb begin
        mem_in  = ({1'b0, cur.addr} >= MEM_LO) && ({1'b0, cur.addr} < MEM_HI);
        io_in   = ({1'b0, cur.addr[7:0]} >= IO_LO) && ({1'b0, cur.addr[7:0]} < IO_HI);
        mem_off = cur.addr - MEM_BASE;
        io_off  = cur.addr[7:0] - IO_BASE;
        hit     = (cur.kind != KIND_NONE) && (cur.io ? io_in : mem_in);
        idx     = cur.io ? (IDX_W'(MEM_WORDS) + IDX_W'(io_off)) : IDX_W'(mem_off);
    end

    // R11: a hit always lands inside the storage
    assert_idx_range_R11: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(idx) < DEPTH));

    // R5: I/O hits land in the I/O bank, memory hits in the memory bank
    assert_bank_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> (cur.io == (int'(idx) >= MEM_WORDS)));

endmodule

// File: rtl/mxbus_regfile.sv
`timescale 1ns/1ps
module mxbus_regfile
    import mxbus_pkg::*;
#(
    parameter int unsigned DEPTH = 24,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  kind_e            kind,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic             rd_strobe_n,
    input  logic             wr_strobe_n,
    input  logic [7:0]       bus_in,
    output logic [7:0]       bus_out,
    output logic             bus_oe
);

    logic       wr_q;
    logic [7:0] wdata_q;
    logic       we;
    logic [7:0] regs [DEPTH];
    logic [7:0] rd_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b1;
            wdata_q <= '0;
        end else begin
            wr_q <= wr_strobe_n;
            if (!wr_strobe_n) wdata_q <= bus_in;
        end
    end

    assign we = wr_strobe_n && !wr_q && hit && is_write(kind);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else if (we && (idx == IDX_W'(i))) q <= wdata_q;
        end
        assign regs[i] = q;
    end

    always_comb begin
        rd_byte = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (idx == IDX_W'(j)) rd_byte = regs[j];
        end
        bus_oe  = !rd_strobe_n && hit && is_read(kind);
        bus_out = bus_oe ? rd_byte : 8'h00;
    end

    // R6: driving only while the read strobe is low
    assert_oe_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !rd_strobe_n);

    // R6: never driving during a write cycle
    assert_oe_not_write_R6: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !is_write(kind));

    // R9: out-of-window cycles leave the lines alone
    assert_oe_window_R9: assert property (@(posedge clk) disable iff (rst)
        !hit |-> !bus_oe);

    // R8: a store follows a clock that saw the write strobe low
    assert_store_after_low_R8: assert property (@(posedge clk) disable iff (rst)
        we |-> $past(!wr_strobe_n));

endmodule

// File: rtl/mxbus_slave.sv
`timescale 1ns/1ps
module mxbus_slave
    import mxbus_pkg::*;
#(
    parameter logic [15:0] MEM_BASE  = 16'h4000,
    parameter int unsigned MEM_WORDS = 16,
    parameter logic [7:0]  IO_BASE   = 8'h80,
    parameter int unsigned IO_WORDS  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    input  logic [7:0]  addr_upper,
    input  logic        addr_latch,
    input  logic        io_space,
    input  logic [1:0]  cyc_status,
    input  logic        rd_strobe_n,
    input  logic        wr_strobe_n,
    output logic [2:0]  cyc_kind,
    output logic [15:0] cyc_addr,
    output logic        cyc_io,
    output logic        cyc_hit
);

    localparam int unsigned DEPTH = MEM_WORDS + IO_WORDS;
    localparam int unsigned IDX_W = $clog2(DEPTH);

    cyc_t             cur;
    logic             hit;
    logic [IDX_W-1:0] idx;

    mxbus_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .addr_latch (addr_latch),
        .bus_in     (bus_in),
        .addr_upper (addr_upper),
        .io_space   (io_space),
        .cyc_status (cyc_status),
        .cur        (cur)
    );

    mxbus_decode #(
        .MEM_BASE  (MEM_BASE),
        .MEM_WORDS (MEM_WORDS),
        .IO_BASE   (IO_BASE),
        .IO_WORDS  (IO_WORDS)
    ) u_decode (
        .clk (clk),
        .rst (rst),
        .cur (cur),
        .hit (hit),
        .idx (idx)
    );

    mxbus_regfile #(
        .DEPTH (DEPTH)
    ) u_regfile (
        .clk         (clk),
        .rst         (rst),
        .kind        (cur.kind),
        .hit         (hit),
        .idx         (idx),
        .rd_strobe_n (rd_strobe_n),
        .wr_strobe_n (wr_strobe_n),
        .bus_in      (bus_in),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe)
    );

    assign cyc_kind = cur.kind;
    assign cyc_addr = cur.addr;
    assign cyc_io   = cur.io;
    assign cyc_hit  = hit;

    // R1: no drive on the first clock after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!bus_oe && cyc_kind == 3'd0 && !cyc_hit));

endmodule

// File: tb/mxbus_slave_bench.sv
`timescale 1ns/1ps
module mxbus_slave_bench;

    localparam int MB = 'h40F8;
    localparam int MW = 16;
    localparam int IB = 'hFC;
    localparam int IW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  addr_upper = 8'h00;
    logic        addr_latch = 1'b0;
    logic        io_space = 1'b0;
    logic [1:0]  cyc_status = 2'b00;
    logic        rd_strobe_n = 1'b1;
    logic        wr_strobe_n = 1'b1;
    logic [2:0]  cyc_kind;
    logic [15:0] cyc_addr;
    logic        cyc_io;
    logic        cyc_hit;

    always #10 clk = ~clk;

    mxbus_slave #(
        .MEM_BASE  (16'h40F8),
        .MEM_WORDS (MW),
        .IO_BASE   (8'hFC),
        .IO_WORDS  (IW)
    ) u_mxbus_slave (
        .clk (clk), .rst (rst), .bus_in (bus_in), .bus_out (bus_out),
        .bus_oe (bus_oe), .addr_upper (addr_upper), .addr_latch (addr_latch),
        .io_space (io_space), .cyc_status (cyc_status),
        .rd_strobe_n (rd_strobe_n), .wr_strobe_n (wr_strobe_n),
        .cyc_kind (cyc_kind), .cyc_addr (cyc_addr), .cyc_io (cyc_io),
        .cyc_hit (cyc_hit)
    );

    int checks = 0;
    int errors = 0;
    bit run = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference
    logic [7:0]  m_mem [MW];
    logic [7:0]  m_iop [IW];
    bit          m_io;
    int          m_kind;
    logic [15:0] m_addr;
    bit          m_wr_prev;
    logic [7:0]  m_wdat;

    function automatic int kind_of(input bit io, input logic [1:0] st);
        if (!io && st == 2'b11) return 1;
        if (!io && st == 2'b10) return 2;
        if (!io && st == 2'b01) return 3;
        if ( io && st == 2'b10) return 4;
        if ( io && st == 2'b01) return 5;
        return 0;
    endfunction

    function automatic bit m_hit();
        int a;
        int lo;
        a  = int'(m_addr);
        lo = int'(m_addr[7:0]);
        if (m_kind == 0) return 0;
        if (m_io) return (lo >= IB) && (lo < IB + IW);
        return (a >= MB) && (a < MB + MW);
    endfunction

    function automatic logic [7:0] m_byte();
        if (m_io) return m_iop[int'(m_addr[7:0]) - IB];
        return m_mem[int'(m_addr) - MB];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MW; i++) m_mem[i] = 8'h00;
            for (int i = 0; i < IW; i++) m_iop[i] = 8'h00;
            m_io = 0; m_kind = 0; m_addr = 16'h0000; m_wr_prev = 1; m_wdat = 8'h00;
        end else begin
            if (wr_strobe_n && !m_wr_prev && (m_kind == 3 || m_kind == 5) && m_hit()) begin
                if (m_io) m_iop[int'(m_addr[7:0]) - IB] = m_wdat;
                else      m_mem[int'(m_addr) - MB] = m_wdat;
            end
            if (!wr_strobe_n) m_wdat = bus_in;
            m_wr_prev = wr_strobe_n;
            if (addr_latch) begin
                m_io   = io_space;
                m_kind = kind_of(io_space, cyc_status);
                m_addr = {addr_upper, bus_in};
            end
        end
        #5;
        if (run && !rst) begin
            bit          e_hit;
            bit          e_oe;
            logic [7:0]  e_out;
            e_hit = m_hit();
            e_oe  = !rd_strobe_n && e_hit && (m_kind == 1 || m_kind == 2 || m_kind == 4);
            e_out = e_oe ? m_byte() : 8'h00;
            chk(cyc_kind == 3'(m_kind), "R4 cycle kind", int'(cyc_kind), m_kind);
            chk(cyc_io == m_io, "R4 space flag", int'(cyc_io), int'(m_io));
            chk(cyc_addr[7:0] == m_addr[7:0], "R2 low address", int'(cyc_addr[7:0]), int'(m_addr[7:0]));
            chk(cyc_addr[15:8] == m_addr[15:8], "R3 upper address", int'(cyc_addr[15:8]), int'(m_addr[15:8]));
            chk(cyc_hit == e_hit, m_io ? "R5 port hit" : "R11 memory hit", int'(cyc_hit), int'(e_hit));
            chk(bus_oe == e_oe, e_hit ? "R6 drive enable" : "R9 drive enable outside window",
                int'(bus_oe), int'(e_oe));
            chk(bus_out == e_out, m_kind == 1 ? "R10 fetch byte" : "R7 read byte",
                int'(bus_out), int'(e_out));
        end
    end

    task automatic bus_cycle(input bit io, input logic [1:0] st, input logic [15:0] a,
                             input logic [7:0] hi, input logic [7:0] wd,
                             output logic [7:0] got);
        bit rd;
        bit wr;
        rd = st[1];
        wr = (st == 2'b01);
        @(negedge clk);
        addr_latch = 1'b1; bus_in = a[7:0]; addr_upper = hi;
        io_space = io; cyc_status = st;
        @(negedge clk);
        addr_latch = 1'b0; bus_in = wr ? wd : 8'h5A;
        rd_strobe_n = !rd; wr_strobe_n = !wr;
        @(negedge clk);
        @(posedge clk);
        #6 got = bus_out;
        @(negedge clk);
        rd_strobe_n = 1'b1; wr_strobe_n = 1'b1; bus_in = 8'hC3;
        @(negedge clk);
    endtask

    task automatic mem_rd(input logic [15:0] a, output logic [7:0] got);
        bus_cycle(1'b0, 2'b10, a, a[15:8], 8'h00, got);
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] unused;
        bus_cycle(1'b0, 2'b01, a, a[15:8], d, unused);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        chk(cyc_kind == 3'd0, "R1 kind after reset", int'(cyc_kind), 0);
        chk(cyc_addr == 16'h0000, "R1 address after reset", int'(cyc_addr), 0);
        chk(!cyc_hit && !cyc_io, "R1 flags after reset", int'({cyc_hit, cyc_io}), 0);
        chk(!bus_oe && bus_out == 8'h00, "R1 bus after reset", int'({bus_oe, bus_out}), 0);
        run = 1;

        mem_rd(16'h40F8, got);
        chk(got == 8'h00, "R1 storage cleared", int'(got), 0);

        mem_wr(16'h40F8, 8'h11);
        mem_rd(16'h40F8, got);
        chk(got == 8'h11, "R8 first memory entry", int'(got), 'h11);

        mem_wr(16'h4107, 8'hEE);
        bus_cycle(1'b0, 2'b11, 16'h4107, 8'h41, 8'h00, got);
        chk(got == 8'hEE, "R10 fetch of last memory entry", int'(got), 'hEE);
        chk(cyc_kind == 3'd1, "R10 fetch reported as kind 1", int'(cyc_kind), 1);
        mem_rd(16'h4107, got);
        chk(got == 8'hEE, "R10 data read of same entry", int'(got), 'hEE);

        mem_wr(16'h4108, 8'h77);
        mem_wr(16'h40F7, 8'h66);
        mem_wr(16'h41F8, 8'h55);
        mem_rd(16'h40F8, got);
        chk(got == 8'h11, "R9 out-of-window writes ignored", int'(got), 'h11);
        mem_rd(16'h4108, got);
        chk(got == 8'h00, "R9 no drive above window", int'(got), 0);

        bus_cycle(1'b1, 2'b01, 16'h00FF, 8'hFF, 8'h99, got);
        bus_cycle(1'b1, 2'b10, 16'h00FF, 8'h33, 8'h00, got);
        chk(got == 8'h99, "R5 port read with foreign upper byte", int'(got), 'h99);
        bus_cycle(1'b1, 2'b01, 16'h00FB, 8'hFB, 8'h44, got);
        bus_cycle(1'b1, 2'b10, 16'h00FC, 8'hFC, 8'h00, got);
        chk(got == 8'h00, "R9 port below window ignored", int'(got), 0);
        mem_rd(16'h40FF, got);
        chk(got == 8'h00, "R11 banks are separate", int'(got), 0);

        // write byte applied across both write-strobe states, replaced after
        bus_cycle(1'b0, 2'b01, 16'h4100, 8'h41, 8'hA7, got);
        mem_rd(16'h4100, got);
        chk(got == 8'hA7, "R8 byte held at strobe rise", int'(got), 'hA7);

        // status combinations with no transfer
        bus_cycle(1'b1, 2'b11, 16'h00FC, 8'hFC, 8'h00, got);
        chk(!bus_oe && got == 8'h00, "R4 kind 0 never drives", int'(got), 0);
        bus_cycle(1'b0, 2'b00, 16'h40F8, 8'h40, 8'h00, got);
        chk(cyc_kind == 3'd0, "R4 idle status gives kind 0", int'(cyc_kind), 0);

        // shared lines change while the latch strobe is low
        @(negedge clk); bus_in = 8'h12; addr_upper = 8'h34;
        @(negedge clk);
        chk(cyc_addr == 16'h40F8, "R2 address held", int'(cyc_addr), 'h40F8);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule